// File: doc/BRIEF.md
# Per-CPU Masked Device Interrupt Router

This block gathers up to 64 device interrupt sources into one shared request vector and routes them to four processors. Each processor owns a 64-bit enable mask. Its pending vector is the bitwise AND of that mask with the request vector, and it gets one level interrupt output that is high while any of its pending bits is set. Two single-cycle event outputs per processor mark the cycles in which a source newly becomes pending for that processor (a post) and in which a pending source goes away (a withdraw).

Device sources raise and lower their request bits through two vectors of one-cycle strobes, one for setting and one for clearing. Software reaches the block through a 64-bit register port. The masks can be read and written. The request vector and the per-CPU pending vectors can only be read. Any access with the wrong size, an unaligned offset, an unmapped register number, or a write to a read-only register does not change any state. Such an access sets a sticky error flag instead.

Top module: `irq_router`

## Requirements
- R1: After reset the request vector, all masks and all pending vectors are zero, and every interrupt output, post and withdraw strobe, rdValid and errFlag are low.
- R2: A 1 on srcSet bit n sets request bit n at the next clock edge. The request vector reads back at register number 1, which is byte offset 0x040.
- R3: The pending vector of CPU c is always the mask of CPU c ANDed with the request vector. It is recomputed on every mask write and every request change, and it reads back at register number 16+c (byte offset 0x400 + 0x40*c).
- R4: cpuIrq[c] is high exactly when the pending vector of CPU c is non-zero. It changes at the same clock edge that registers the event causing the change.
- R5: cpuPost[c] is high for one cycle after any edge at which some pending bit of CPU c goes from 0 to 1. The cause can be a mask bit rising or a request bit rising.
- R6: cpuWithdraw[c] is high for one cycle after any edge at which some pending bit of CPU c goes from 1 to 0. The cause can be a mask bit falling or a request bit falling.
- R7: A 1 on srcClr bit n clears request bit n. A clear of a bit that is already 0 changes no state and raises no strobe.
- R8: Set and clear strobes on different bits in the same cycle are both applied, and the pending vectors use the result. When one bit is both set and cleared in the same cycle, the set wins.
- R9: A legal 64-bit write to register number 8+c (byte offset 0x200 + 0x40*c) replaces the mask of CPU c. That mask reads back at the same address.
- R10: An access is illegal if its size is not 8 bytes or if byte offset bits [5:0] are not zero. An illegal access changes no mask, sets errFlag, and errFlag then stays set until reset.
- R11: A write to the request or pending registers, or any access to an unmapped register number, is illegal. It changes no state, sets errFlag, and a read of that kind returns zero.
- R12: Every read, legal or not, gives rdValid one cycle later. rdData then holds the register value from before that cycle's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcSet | input | 64 | One-cycle per-source request set strobes |
| srcClr | input | 64 | One-cycle per-source request clear strobes |
| regValid | input | 1 | Register access present this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 12 | Byte offset; register number is regAddr[11:6] |
| regSize | input | 4 | Access size in bytes; only 8 is legal |
| regWdata | input | 64 | Write data |
| rdValid | output | 1 | Read response valid |
| rdData | output | 64 | Read response data |
| cpuIrq | output | 4 | Level interrupt per CPU |
| cpuPost | output | 4 | One-cycle new-pending event per CPU |
| cpuWithdraw | output | 4 | One-cycle pending-removed event per CPU |
| errFlag | output | 1 | Sticky illegal-access flag |

## Verification
The bench targets a set and a clear of the same bit in one cycle. A design that let the clear win would leave the request bit low and miss a post. It targets clears of bits that are already zero, where a sloppy design would raise a withdraw strobe. It also covers mask writes that enable a source that is already requesting: if pending were updated only on request edges, that post would never occur. Illegal writes to the pending and request registers, wrong sizes and unaligned offsets are all applied, followed by read-back. A decoder that partly accepted them would corrupt a mask or leave errFlag low. Seeded random traffic then mixes all of these cases against a bench model.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  // Maximum CPU slots carried by the control strobe bundle.
  localparam int MAX_CPU   = 4;
  localparam int CPU_IDX_W = $clog2(MAX_CPU);

  // Register numbers (byte offset >> 6).
  localparam int REG_REQ       = 1;
  localparam int REG_MASK_BASE = 8;
  localparam int REG_PEND_BASE = 16;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_REQ  = 2'd1,
    RD_MASK = 2'd2,
    RD_PEND = 2'd3
  } rdKind_e;

  typedef struct packed {
    logic [MAX_CPU-1:0]   maskWe;
    logic                 rdEn;
    rdKind_e              rdKind;
    logic [CPU_IDX_W-1:0] rdIdx;
  } ctrlStrobe_t;

endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [3:0]        regSize,
  output ctrlStrobe_t       strobe,
  output logic              errFlag
);

  localparam int RN_W = ADDR_W - 6;
  localparam logic [3:0] SIZE_BYTES = 4'(NUM_SRC / 8);

  logic [RN_W-1:0]      regNum;
  logic                 aligned;
  logic                 sizeOk;
  logic                 hitReq;
  logic                 hitMask;
  logic                 hitPend;
  logic                 legal;
  logic                 illegal;
  logic [CPU_IDX_W-1:0] maskIdx;
  logic [CPU_IDX_W-1:0] pendIdx;

  always_comb begin
    regNum  = regAddr[ADDR_W-1:6];
    aligned = (regAddr[5:0] == 6'd0);
    sizeOk  = (regSize == SIZE_BYTES);
    hitReq  = (regNum == RN_W'(REG_REQ));
    hitMask = (regNum >= RN_W'(REG_MASK_BASE)) &&
              (regNum <  RN_W'(REG_MASK_BASE + NUM_CPU));
    hitPend = (regNum >= RN_W'(REG_PEND_BASE)) &&
              (regNum <  RN_W'(REG_PEND_BASE + NUM_CPU));
    maskIdx = CPU_IDX_W'(regNum - RN_W'(REG_MASK_BASE));
    pendIdx = CPU_IDX_W'(regNum - RN_W'(REG_PEND_BASE));

    legal   = regValid && aligned && sizeOk &&
              (hitMask || (!regWrite && (hitReq || hitPend)));
    illegal = regValid && !legal;

    strobe        = '0;
    strobe.rdKind = RD_ZERO;
    strobe.rdEn   = regValid && !regWrite;
    if (legal) begin
      if (regWrite) begin
        strobe.maskWe[maskIdx] = 1'b1;
      end else if (hitReq) begin
        strobe.rdKind = RD_REQ;
      end else if (hitMask) begin
        strobe.rdKind = RD_MASK;
        strobe.rdIdx  = maskIdx;
      end else begin
        strobe.rdKind = RD_PEND;
        strobe.rdIdx  = pendIdx;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
    end else if (illegal) begin
      errFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcSet,
  input  logic [NUM_SRC-1:0] srcClr,
  input  logic [NUM_SRC-1:0] wrData,
  input  ctrlStrobe_t        strobe,
  output logic               rdValid,
  output logic [NUM_SRC-1:0] rdData,
  output logic [NUM_CPU-1:0] cpuIrq,
  output logic [NUM_CPU-1:0] cpuPost,
  output logic [NUM_CPU-1:0] cpuWithdraw
);

  logic [NUM_SRC-1:0] reqQ;
  logic [NUM_SRC-1:0] reqD;
  logic [NUM_SRC-1:0] maskQ [NUM_CPU];
  logic [NUM_SRC-1:0] maskD [NUM_CPU];
  logic [NUM_SRC-1:0] pendQ [NUM_CPU];
  logic [NUM_SRC-1:0] pendD [NUM_CPU];

  // Set wins over clear on the same bit.
  always_comb begin
    reqD = (reqQ & ~srcClr) | srcSet;
    for (int c = 0; c < NUM_CPU; c++) begin
      maskD[c] = strobe.maskWe[c] ? wrData : maskQ[c];
      pendD[c] = maskD[c] & reqD;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ        <= '0;
      cpuIrq      <= '0;
      cpuPost     <= '0;
      cpuWithdraw <= '0;
      for (int c = 0; c < NUM_CPU; c++) begin
        maskQ[c] <= '0;
        pendQ[c] <= '0;
      end
    end else begin
      reqQ <= reqD;
      for (int c = 0; c < NUM_CPU; c++) begin
        maskQ[c]       <= maskD[c];
        pendQ[c]       <= pendD[c];
        cpuIrq[c]      <= |pendD[c];
        cpuPost[c]     <= |(pendD[c] & ~pendQ[c]);
        cpuWithdraw[c] <= |(pendQ[c] & ~pendD[c]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.rdEn;
      if (strobe.rdEn) begin
        case (strobe.rdKind)
          RD_REQ:  rdData <= reqQ;
          RD_MASK: rdData <= maskQ[strobe.rdIdx];
          RD_PEND: rdData <= pendQ[strobe.rdIdx];
          default: rdData <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcSet,
  input  logic [NUM_SRC-1:0] srcClr,
  input  logic               regValid,
  input  logic               regWrite,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [3:0]         regSize,
  input  logic [NUM_SRC-1:0] regWdata,
  output logic               rdValid,
  output logic [NUM_SRC-1:0] rdData,
  output logic [NUM_CPU-1:0] cpuIrq,
  output logic [NUM_CPU-1:0] cpuPost,
  output logic [NUM_CPU-1:0] cpuWithdraw,
  output logic               errFlag
);

  ctrlStrobe_t strobe;

  irq_router_ctrl #(
    .NUM_CPU(NUM_CPU),
    .NUM_SRC(NUM_SRC),
    .ADDR_W (ADDR_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .regValid(regValid),
    .regWrite(regWrite),
    .regAddr (regAddr),
    .regSize (regSize),
    .strobe  (strobe),
    .errFlag (errFlag)
  );

  irq_router_dp #(
    .NUM_CPU(NUM_CPU),
    .NUM_SRC(NUM_SRC)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .srcSet     (srcSet),
    .srcClr     (srcClr),
    .wrData     (regWdata),
    .strobe     (strobe),
    .rdValid    (rdValid),
    .rdData     (rdData),
    .cpuIrq     (cpuIrq),
    .cpuPost    (cpuPost),
    .cpuWithdraw(cpuWithdraw)
  );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_CPU = 4,
  parameter int NUM_SRC = 64
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcSet,
  input logic [NUM_SRC-1:0] srcClr,
  input logic               regValid,
  input logic               regWrite,
  input logic [3:0]         regSize,
  input logic               rdValid,
  input logic [NUM_CPU-1:0] cpuIrq,
  input logic [NUM_CPU-1:0] cpuPost,
  input logic [NUM_CPU-1:0] cpuWithdraw,
  input logic               errFlag
);

  localparam logic [3:0] SIZE_BYTES = 4'(NUM_SRC / 8);

  for (genvar c = 0; c < NUM_CPU; c++) begin : gCpu
    p_post_level_r5: assert property (@(posedge clk) disable iff (!rstN)
      cpuPost[c] |-> cpuIrq[c]);
    p_irq_rise_post_r4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(cpuIrq[c]) |-> cpuPost[c]);
    p_irq_fall_withdraw_r6: assert property (@(posedge clk) disable iff (!rstN)
      $fell(cpuIrq[c]) |-> cpuWithdraw[c]);
  end

  p_quiet_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!regValid && srcSet == '0 && srcClr == '0)
      |=> ($stable(cpuIrq) && cpuPost == '0 && cpuWithdraw == '0));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  p_bad_size_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regSize != SIZE_BYTES) |=> errFlag);

  p_rd_resp_r12: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regWrite) |=> rdValid);

  p_no_spurious_rd_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(regValid && !regWrite) |=> !rdValid);

endmodule

bind irq_router irq_router_chk #(
  .NUM_CPU(NUM_CPU),
  .NUM_SRC(NUM_SRC)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .srcSet     (srcSet),
  .srcClr     (srcClr),
  .regValid   (regValid),
  .regWrite   (regWrite),
  .regSize    (regSize),
  .rdValid    (rdValid),
  .cpuIrq     (cpuIrq),
  .cpuPost    (cpuPost),
  .cpuWithdraw(cpuWithdraw),
  .errFlag    (errFlag)
);

// File: tb/tb_irq_router.sv
module tb_irq_router;

  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] srcSet = '0;
  logic [63:0] srcClr = '0;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [11:0] regAddr = '0;
  logic [3:0]  regSize = 4'd8;
  logic [63:0] regWdata = '0;
  logic        rdValid;
  logic [63:0] rdData;
  logic [3:0]  cpuIrq;
  logic [3:0]  cpuPost;
  logic [3:0]  cpuWithdraw;
  logic        errFlag;

  int testsRun = 0;
  int testsFailed = 0;

  // Bench model
  logic [63:0] mReq;
  logic [63:0] mMask [NCPU];
  logic        mErr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_router dut (
    .clk(clk), .rstN(rstN), .srcSet(srcSet), .srcClr(srcClr),
    .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr),
    .regSize(regSize), .regWdata(regWdata), .rdValid(rdValid),
    .rdData(rdData), .cpuIrq(cpuIrq), .cpuPost(cpuPost),
    .cpuWithdraw(cpuWithdraw), .errFlag(errFlag)
  );

  function automatic logic [11:0] maskAddr(int c);
    return 12'((8 + c) << 6);
  endfunction

  function automatic logic [11:0] pendAddr(int c);
    return 12'((16 + c) << 6);
  endfunction

  localparam logic [11:0] REQ_ADDR = 12'h040;

  function automatic logic isIllegal(logic v, logic w, logic [11:0] a, logic [3:0] sz);
    int rn;
    logic isMask, mapped;
    if (!v) return 1'b0;
    if (sz != 4'd8 || a[5:0] != 6'd0) return 1'b1;
    rn = int'(a[11:6]);
    isMask = (rn >= 8 && rn < 12);
    mapped = (rn == 1) || isMask || (rn >= 16 && rn < 20);
    if (!mapped) return 1'b1;
    if (w && !isMask) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [63:0] expRead(logic [11:0] a, logic [3:0] sz);
    int rn;
    if (isIllegal(1'b1, 1'b0, a, sz)) return '0;
    rn = int'(a[11:6]);
    if (rn == 1) return mReq;
    if (rn >= 8 && rn < 12) return mMask[rn - 8];
    return mMask[rn - 16] & mReq;
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Called at a negedge: drives one cycle, waits a full cycle, checks.
  task automatic step(input logic [63:0] s, input logic [63:0] c,
                      input logic v, input logic w, input logic [11:0] a,
                      input logic [3:0] sz, input logic [63:0] d,
                      input string tag);
    logic [63:0] oldPend [NCPU];
    logic [63:0] newPend [NCPU];
    logic [3:0]  eIrq, ePost, eWd;
    logic [63:0] eRd;
    logic        ill;
    logic        isRd;
    srcSet = s; srcClr = c; regValid = v; regWrite = w;
    regAddr = a; regSize = sz; regWdata = d;
    ill  = isIllegal(v, w, a, sz);
    isRd = v && !w;
    eRd  = isRd ? expRead(a, sz) : 64'd0;
    for (int k = 0; k < NCPU; k++) oldPend[k] = mMask[k] & mReq;
    if (v && w && !ill) mMask[int'(a[11:6]) - 8] = d;
    mReq = (mReq & ~c) | s;
    if (ill) mErr = 1'b1;
    for (int k = 0; k < NCPU; k++) begin
      newPend[k] = mMask[k] & mReq;
      eIrq[k]  = |newPend[k];
      ePost[k] = |(newPend[k] & ~oldPend[k]);
      eWd[k]   = |(oldPend[k] & ~newPend[k]);
    end
    @(negedge clk);
    srcSet = '0; srcClr = '0; regValid = 1'b0; regWrite = 1'b0;
    check(cpuIrq == eIrq, tag, "cpuIrq", 64'(cpuIrq), 64'(eIrq));
    check(cpuPost == ePost, tag, "cpuPost", 64'(cpuPost), 64'(ePost));
    check(cpuWithdraw == eWd, tag, "cpuWithdraw", 64'(cpuWithdraw), 64'(eWd));
    check(errFlag == mErr, tag, "errFlag", 64'(errFlag), 64'(mErr));
    check(rdValid == isRd, tag, "rdValid", 64'(rdValid), 64'(isRd));
    if (isRd) check(rdData == eRd, tag, "rdData", rdData, eRd);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    step('0, '0, 1'b1, 1'b0, a, 4'd8, '0, tag);
  endtask

  task automatic wrMask(input int c, input logic [63:0] d, input string tag);
    step('0, '0, 1'b1, 1'b1, maskAddr(c), 4'd8, d, tag);
  endtask

  task automatic src(input logic [63:0] s, input logic [63:0] c, input string tag);
    step(s, c, 1'b0, 1'b0, '0, 4'd8, '0, tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    srcSet = '0; srcClr = '0; regValid = 1'b0; regWrite = 1'b0;
    mReq = '0; mErr = 1'b0;
    for (int k = 0; k < NCPU; k++) mMask[k] = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    testsFailed++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    doReset();
    // R1: reset state
    check(cpuIrq == 4'd0 && cpuPost == 4'd0 && cpuWithdraw == 4'd0, "R1",
          "irq/post/withdraw", 64'({cpuIrq, cpuPost, cpuWithdraw}), 64'd0);
    check(errFlag == 1'b0 && rdValid == 1'b0, "R1", "err/rdValid",
          64'({errFlag, rdValid}), 64'd0);
    rd(REQ_ADDR, "R1");
    rd(pendAddr(3), "R1");

    // R9: mask write and read back
    wrMask(0, 64'h0000_0000_0000_00F0, "R9");
    rd(maskAddr(0), "R9");

    // R2/R4/R5: source rise with mask set posts to CPU0 only
    src(64'h10, '0, "R5");
    rd(REQ_ADDR, "R2");
    rd(pendAddr(0), "R3");
    rd(pendAddr(1), "R3");

    // R5: mask rise on an already requesting source posts to CPU1
    wrMask(1, 64'h8000_0000_0000_0010, "R5");
    check(cpuIrq == 4'b0011, "R4", "irq after mask rise", 64'(cpuIrq), 64'h3);

    // R7: spurious clear of an idle bit does nothing
    src('0, 64'h80, "R7");
    rd(REQ_ADDR, "R7");

    // R8: different bits set and cleared together
    src(64'h20, 64'h10, "R8");
    rd(REQ_ADDR, "R8");
    // R8: same bit set and cleared, set wins
    src(64'h8000_0000_0000_0200, 64'h0000_0000_0000_0200, "R8");
    rd(REQ_ADDR, "R8");

    // R6: mask fall withdraws from CPU0
    wrMask(0, 64'h0, "R6");
    // R6/R7: request clear withdraws from CPU1
    src('0, '1, "R6");
    rd(pendAddr(1), "R3");

    // R10: wrong size write leaves mask unchanged, error sticky
    step('0, '0, 1'b1, 1'b1, maskAddr(2), 4'd4, 64'hFFFF, "R10");
    rd(maskAddr(2), "R10");
    src('0, '0, "R10");
    doReset();
    // R10: unaligned write is rejected
    step('0, '0, 1'b1, 1'b1, maskAddr(2) | 12'h008, 4'd8, 64'hFF, "R10");
    rd(maskAddr(2), "R10");

    // R11: writes to request and pending registers are rejected
    doReset();
    src(64'h3, '0, "R11");
    step('0, '0, 1'b1, 1'b1, pendAddr(0), 4'd8, '1, "R11");
    step('0, '0, 1'b1, 1'b1, REQ_ADDR, 4'd8, '0, "R11");
    rd(REQ_ADDR, "R11");
    rd(pendAddr(0), "R11");
    doReset();
    // R11: unmapped read returns zero
    src(64'h1, '0, "R11");
    rd(12'h0C0, "R11");

    // R12: read reflects value before the edge of the same cycle
    doReset();
    wrMask(2, 64'h4, "R12");
    step(64'h4, '0, 1'b1, 1'b0, pendAddr(2), 4'd8, '0, "R12");
    rd(pendAddr(2), "R12");

    // Random traffic
    doReset();
    for (int i = 0; i < 600; i++) begin
      logic [63:0] s, c, d;
      logic        v, w;
      logic [11:0] a;
      logic [3:0]  sz;
      int          kind;
      s = ($urandom_range(0, 2) == 0) ? (64'd1 << $urandom_range(0, 63)) : 64'd0;
      c = ($urandom_range(0, 2) == 0) ? (64'd1 << $urandom_range(0, 63)) : 64'd0;
      if ($urandom_range(0, 9) == 0) s = s | {$urandom(), $urandom()};
      if ($urandom_range(0, 9) == 0) c = c | {$urandom(), $urandom()};
      d = {$urandom(), $urandom()};
      kind = $urandom_range(0, 9);
      v = (kind < 5); w = 1'b0; sz = 4'd8; a = '0;
      case (kind)
        0, 1: begin w = 1'b1; a = maskAddr($urandom_range(0, 3)); end
        2: a = REQ_ADDR;
        3: a = ($urandom_range(0, 1) == 0) ? maskAddr($urandom_range(0, 3))
                                           : pendAddr($urandom_range(0, 3));
        4: begin
          w = ($urandom_range(0, 1) == 1);
          a = 12'($urandom_range(0, 4095));
          sz = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'd8;
        end
        default: ;
      endcase
      step(s, c, v, w, a, sz, d, "R3");
      if (i % 150 == 149) doReset();
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule